// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Divider

This block derives the bit clock of a synchronous serial port from the system clock. Two programmable dividers sit in cascade: a first stage divides by an even prescale value, and a second stage divides by one plus an 8-bit rate value. The resulting bit clock runs at the system clock frequency divided by the product of the two divisors, with a 50% duty cycle.

The bit clock is produced as a registered level together with single-cycle rising and falling edge strobes in the system clock domain, so that shift logic downstream can stay fully synchronous. A combinational flag reports a divider setting that cannot be honoured: a prescale value that is zero or odd, or, in slave mode, a total ratio below 12. While the flag is high or the enable is low, both counters are cleared and the bit clock idles low. All pins are plain control and status; there is no streaming data path, so no valid/ready handshake applies.

Top module: `bitclk_divider`

## Requirements
- R1: While running with a fixed setting, every high phase and every low phase of `bclk` lasts exactly (presc/2) x (rate+1) system clock cycles.
- R2: The rate input spans 0 to 255, giving a second-stage divisor of 1 to 256; rate = 255 with presc = 2 gives half phases of 256 cycles.
- R3: A prescale value of 0 or any odd value sets `cfg_bad`; while `cfg_bad` is high, `bclk` stays low and neither strobe pulses.
- R4: With `slave_mode` = 1, `cfg_bad` is high whenever presc x (rate+1) is below 12; with `slave_mode` = 0, any even non-zero presc is legal (minimum ratio 2 is always met).
- R5: While `en` is low, `bclk` is low (from the first clock edge at which `en` is sampled low), and both counters restart, so that after `en` is sampled high at some edge, `bclk` first goes high at the edge one full half phase later (counting that edge as the first).
- R6: `bclk_rise` is high for exactly the one cycle in which `bclk` is first high, and `bclk_fall` for exactly the one cycle in which `bclk` is first low after a high phase; the two are never high together.
- R7: After reset, `bclk`, `bclk_rise` and `bclk_fall` are all low.
- R8: The largest setting, presc = 254 and rate = 255, gives half phases of 32512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider idle |
| presc | input | 8 | First-stage divisor, legal values even 2..254 |
| rate | input | 8 | Second-stage divisor minus one |
| slave_mode | input | 1 | 1 selects the slave ratio limit of 12, 0 the master limit of 2 |
| bclk | output | 1 | Generated bit clock level |
| bclk_rise | output | 1 | One-cycle strobe in the first cycle of a high phase |
| bclk_fall | output | 1 | One-cycle strobe in the first cycle of a low phase |
| cfg_bad | output | 1 | Divider setting cannot be honoured |

## Verification
`cfg_bad` is combinational and is checked one time step after the inputs change, with no clock edge in between. The bit clock and both strobes are registered together, so the bench drives `en` and the setting on a falling edge, samples on every following falling edge, and expects the first high level and the rise strobe on the sample after exactly one half phase of rising edges; each further phase length is counted the same way and the fall strobe is expected on the first low sample. Disabling is checked on the sample after the first rising edge that sees `en` low.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  localparam int unsigned PRESC_W    = 8;
  localparam int unsigned RATE_W     = 8;
  localparam int unsigned MASTER_MIN = 2;
  localparam int unsigned SLAVE_MIN  = 12;
endpackage

// File: rtl/bitclk_presc_stage.sv
module bitclk_presc_stage #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  localparam int unsigned CW = PW - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  assign half = presc[PW-1:1];
  assign tick = run && (cnt >= half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1: with a stable setting the first-stage count stays below presc/2
  a_r1_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(presc)) |-> (cnt < half));

  // R5: an idle cycle leaves the first stage cleared
  a_r5_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/bitclk_rate_stage.sv
module bitclk_rate_stage #(
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [RW-1:0] rate,
  output logic          wrap
);
  logic [RW-1:0] cnt;

  assign wrap = tick && (cnt >= rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R2: with a stable rate the tick count never passes the rate value
  a_r2_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(rate)) |-> (cnt <= rate));

  // R5: an idle cycle leaves the second stage cleared
  a_r5_rate_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/bitclk_ratio_guard.sv
module bitclk_ratio_guard
  import bitclk_pkg::*;
#(
  parameter int unsigned PW = PRESC_W,
  parameter int unsigned RW = RATE_W
) (
  input  logic [PW-1:0] presc,
  input  logic [RW-1:0] rate,
  input  logic          slave_mode,
  output logic          bad
);
  localparam int unsigned XW = PW + RW + 1;

  logic [XW-1:0] ratio;
  logic [XW-1:0] floor_v;
  logic          presc_ok;

  assign ratio    = XW'(presc) * (XW'(rate) + 1'b1);
  assign floor_v  = slave_mode ? XW'(SLAVE_MIN) : XW'(MASTER_MIN);
  assign presc_ok = (presc != '0) && !presc[0];
  assign bad      = !presc_ok || (ratio < floor_v);

  // R3: zero or odd prescale always flagged
  always_comb begin
    a_r3_odd_flag: assert (!(presc[0] || presc == '0) || bad);
  end
endmodule

// File: rtl/bitclk_divider.sv
module bitclk_divider
  import bitclk_pkg::*;
#(
  parameter int unsigned PW = PRESC_W,
  parameter int unsigned RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] presc,
  input  logic [RW-1:0] rate,
  input  logic          slave_mode,
  output logic          bclk,
  output logic          bclk_rise,
  output logic          bclk_fall,
  output logic          cfg_bad
);
  logic run;
  logic tick;
  logic wrap;

  bitclk_ratio_guard #(.PW(PW), .RW(RW)) u_guard (
    .presc      (presc),
    .rate       (rate),
    .slave_mode (slave_mode),
    .bad        (cfg_bad)
  );

  assign run = en && !cfg_bad;

  bitclk_presc_stage #(.PW(PW)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .presc (presc),
    .tick  (tick)
  );

  bitclk_rate_stage #(.RW(RW)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .rate  (rate),
    .wrap  (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk      <= 1'b0;
      bclk_rise <= 1'b0;
      bclk_fall <= 1'b0;
    end else if (!run) begin
      bclk      <= 1'b0;
      bclk_rise <= 1'b0;
      bclk_fall <= 1'b0;
    end else begin
      bclk_rise <= wrap && !bclk;
      bclk_fall <= wrap && bclk;
      if (wrap) bclk <= !bclk;
    end
  end

  // R6: a rise strobe marks the first high cycle
  a_r6_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_rise) |-> (bclk && !$past(bclk)));

  // R6: a fall strobe marks the first low cycle after a high phase
  a_r6_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |-> (!bclk && $past(bclk)));

  // R6: strobes never overlap and never last two cycles
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bclk_rise, bclk_fall}) && !(bclk_rise && $past(bclk_rise)));

  // R3 and R5: an idle or illegal setting forces the clock low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !cfg_bad) |=> (!bclk && !bclk_rise && !bclk_fall));
endmodule

// File: tb/test_bitclk_divider.sv
module test_bitclk_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] presc = 8'd2;
  logic [7:0] rate = 8'd0;
  logic       slave_mode = 1'b0;
  logic       bclk, bclk_rise, bclk_fall, cfg_bad;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitclk_divider i_bitclk_divider (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .rate(rate),
    .slave_mode(slave_mode), .bclk(bclk), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .cfg_bad(cfg_bad)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic t_reset;
    @(negedge clk);
    check(bclk == 1'b0, "R7 bclk", int'(bclk), 0);
    check(bclk_rise == 1'b0 && bclk_fall == 1'b0, "R7 strobes",
          int'({bclk_rise, bclk_fall}), 0);
  endtask

  // Measures phases; full=1 also measures the low phase after the high one.
  task automatic t_divide(input int p, input int r, input bit sl, input bit full, input string req);
    int h, n, m;
    @(negedge clk);
    en = 1'b0;
    presc = 8'(p); rate = 8'(r); slave_mode = sl;
    @(negedge clk);
    check(bclk == 1'b0, "R5 idle low", int'(bclk), 0);
    check(cfg_bad == 1'b0, {req, " legal"}, int'(cfg_bad), 0);
    h = (p / 2) * (r + 1);
    en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bclk && n <= h + 4);
    check(n == h, {req, " first rise R5"}, n, h);
    check(bclk_rise && !bclk_fall, "R6 rise strobe", int'({bclk_rise, bclk_fall}), 2);
    m = 1;
    while (bclk && m <= h + 4) begin
      @(negedge clk);
      if (bclk) begin
        m++;
        if (m == 2) check(!bclk_rise, "R6 rise single", int'(bclk_rise), 0);
      end
    end
    check(m == h, {req, " high phase R1"}, m, h);
    check(bclk_fall && !bclk_rise, "R6 fall strobe", int'({bclk_rise, bclk_fall}), 1);
    if (full) begin
      m = 1;
      do begin
        @(negedge clk);
        if (!bclk) m++;
      end while (!bclk && m <= h + 4);
      check(m == h, {req, " low phase R1"}, m, h);
    end
    en = 1'b0;
    @(negedge clk);
    check(bclk == 1'b0, "R5 disable", int'(bclk), 0);
  endtask

  task automatic t_bad(input int p, input int r, input bit sl, input bit exp_bad, input string req);
    bit seen;
    @(negedge clk);
    en = 1'b0;
    presc = 8'(p); rate = 8'(r); slave_mode = sl;
    #1;
    check(cfg_bad == exp_bad, req, int'(cfg_bad), int'(exp_bad));
    if (exp_bad) begin
      en = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bclk || bclk_rise || bclk_fall) seen = 1'b1;
      end
      check(!seen, {req, " held low R3"}, int'(seen), 0);
      en = 1'b0;
    end
  endtask

  task automatic t_restart;
    // enable, stop mid high phase, re-enable: full half phase again
    @(negedge clk);
    presc = 8'd4; rate = 8'd2; slave_mode = 1'b0; en = 1'b1;
    repeat (8) @(negedge clk);
    check(bclk == 1'b1, "R5 mid high", int'(bclk), 1);
    en = 1'b0;
    @(negedge clk);
    check(bclk == 1'b0 && !bclk_fall, "R5 stop low", int'({bclk, bclk_fall}), 0);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check(bclk == 1'b0, "R5 restart not early", int'(bclk), 0);
    @(negedge clk);
    check(bclk == 1'b1, "R5 restart on time", int'(bclk), 1);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divide(2, 0, 1'b0, 1'b1, "R4 master min");
    t_divide(4, 2, 1'b0, 1'b1, "R1 p4 r2");
    t_divide(6, 3, 1'b1, 1'b1, "R1 slave p6 r3");
    t_divide(10, 0, 1'b0, 1'b1, "R1 p10 r0");
    t_divide(2, 255, 1'b0, 1'b1, "R2 rate max");
    t_divide(4, 2, 1'b1, 1'b0, "R4 slave ratio 12");
    t_divide(2, 5, 1'b1, 1'b0, "R4 slave p2 r5");
    t_bad(0, 3, 1'b0, 1'b1, "R3 presc zero");
    t_bad(5, 3, 1'b0, 1'b1, "R3 presc odd");
    t_bad(255, 0, 1'b1, 1'b1, "R3 presc 255");
    t_bad(2, 4, 1'b1, 1'b1, "R4 slave ratio 10");
    t_bad(2, 0, 1'b1, 1'b1, "R4 slave ratio 2");
    t_bad(2, 4, 1'b0, 1'b0, "R4 master ratio 10");
    t_restart();
    t_divide(254, 255, 1'b0, 1'b0, "R8 largest");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule